// File: doc/BRIEF.md
# Host Command Supervisor

This block is the supervisory state machine that sits between a byte stream from a host computer and the drivers of a deformable mirror. After reset it waits for the host link to report ready. It then asks for the high-voltage amplifiers to be powered up. Once that is done it rests in a main wait state. In that state it scans received bytes for a three-byte command frame: the byte 0xFF, then 0x00, then an operation code. The decoded operation is dispatched as a level request to the matching subsystem, and the machine returns to the main state when that subsystem reports completion.

The four operations are as follows. A run passes the following data bytes to the output update path. A self test reports a pass or fail byte back to the host. A shutdown requests amplifier power-down. A status query returns a single status byte. A host-cleared watchdog runs while the amplifiers are powered and the machine sits in the main or run state. If the host stops clearing it, the machine forces the shutdown path, so the mirror is never left driven by a host that has gone away.

Top module: `host_cmd_supervisor`

## Requirements
- R1: After reset all request and reply outputs are low. The machine waits until `link_ready_i` is high. It then holds `pwr_up_req_o` high until `pwr_up_done_i`, and then enters the main state.
- R2: In the main state, the received bytes 0xFF, 0x00 and then an operation code dispatch the operation in the cycle after the code byte. The codes are 0x01 for run, 0x02 for self test, 0x03 for shutdown and 0x04 for status.
- R3: An operation code other than 0x01 to 0x04 is ignored. No request or reply follows, and the detector searches for 0xFF again.
- R4: A received 0xFF at any point of a frame restarts the frame at its second byte. Any other byte that does not continue the frame returns the detector to searching for 0xFF.
- R5: While running, `run_o` is high and each received byte appears on `run_data_o` with `run_valid_o` in the same cycle. The run ends on `run_done_i` or on `wdt_clr_i`.
- R6: During a self test, `test_start_o` stays high until `test_done_i`. The cycle after completion carries a one-cycle reply: 0x4F if `test_pass_i` was high, 0x45 if not.
- R7: A status command produces, two cycles after the code byte, a one-cycle reply of 0xA0 plus 4 if the amplifiers are on, plus 2 if the watchdog has fired since the last power-up, plus 1 if the last self test passed.
- R8: A shutdown holds `pwr_dn_req_o` high until `pwr_dn_done_i`. The amplifiers then count as off, and the machine returns to the main state.
- R9: The watchdog runs only while the amplifiers are on and the machine is in the main or run state. It counts cycles without `wdt_clr_i`. In the cycle in which the count equals `wdt_limit_i`, it expires and forces the shutdown path.
- R10: Watchdog expiry takes priority over a command frame that completes in the same cycle. A `wdt_clr_i` in the cycle where the count equals `wdt_limit_i` prevents the expiry.
- R11: Bytes received outside the main state are not taken as frame bytes, and a frame never spans a stay outside the main state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_ready_i | input | 1 | Host link module ready |
| pwr_up_done_i | input | 1 | Amplifier power-up sequence finished |
| pwr_dn_done_i | input | 1 | Amplifier power-down sequence finished |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| wdt_clr_i | input | 1 | Host watchdog clear |
| wdt_limit_i | input | WDT_W | Watchdog timeout in cycles |
| run_done_i | input | 1 | All outputs updated, end of run |
| test_done_i | input | 1 | Self test finished |
| test_pass_i | input | 1 | Self test result, valid with test_done_i |
| pwr_up_req_o | output | 1 | Request amplifier power-up |
| pwr_dn_req_o | output | 1 | Request amplifier power-down |
| run_o | output | 1 | Run in progress |
| run_valid_o | output | 1 | Data byte for the output update path |
| run_data_o | output | 8 | Data byte for the output update path |
| test_start_o | output | 1 | Self test in progress |
| tx_valid_o | output | 1 | Reply byte strobe to host |
| tx_data_o | output | 8 | Reply byte to host |

## Verification
The collision of interest is watchdog expiry against a command frame that completes in the same cycle. A second collision is expiry against a host clear that arrives in that very cycle. The bench clears the watchdog and idles for a counted number of cycles. It then places either the run code byte or a clear exactly on the cycle where the count reaches the limit. In the first case it judges that shutdown is requested and no run starts. In the second case it judges that no shutdown follows. A behavioural reference model, compared every clock, confirms all other cycles around both events.

// File: rtl/host_sup_pkg.sv
package host_sup_pkg;
  localparam logic [7:0] SYNC_HI  = 8'hFF;
  localparam logic [7:0] SYNC_LO  = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_TEST  = 8'h02;
  localparam logic [7:0] OP_SHUT  = 8'h03;
  localparam logic [7:0] OP_STAT  = 8'h04;
  localparam logic [7:0] RPL_PASS = 8'h4F;
  localparam logic [7:0] RPL_FAIL = 8'h45;
  localparam logic [3:0] STAT_TAG = 4'hA;

  typedef enum logic [2:0] {
    S_BOOT, S_PWRUP, S_MAIN, S_RUN, S_TEST, S_STAT, S_SHUT
  } sup_state_e;

  typedef enum logic [1:0] {F_SEEK_HI, F_SEEK_LO, F_SEEK_OP} frm_state_e;

  typedef enum logic [1:0] {C_RUN, C_TEST, C_SHUT, C_STAT} cmd_e;
endpackage

// File: rtl/sup_frame_detect.sv
module sup_frame_detect
  import host_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output cmd_e       cmd_o
);
  frm_state_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    hit_o = 1'b0;
    cmd_o = C_RUN;
    if (!en_i) begin
      st_d = F_SEEK_HI;
    end else if (byte_valid_i) begin
      if (byte_i == SYNC_HI) begin
        st_d = F_SEEK_LO;  // resync at any position
      end else begin
        case (st_q)
          F_SEEK_LO: st_d = (byte_i == SYNC_LO) ? F_SEEK_OP : F_SEEK_HI;
          F_SEEK_OP: begin
            st_d = F_SEEK_HI;
            case (byte_i)
              OP_RUN:  begin hit_o = 1'b1; cmd_o = C_RUN;  end
              OP_TEST: begin hit_o = 1'b1; cmd_o = C_TEST; end
              OP_SHUT: begin hit_o = 1'b1; cmd_o = C_SHUT; end
              OP_STAT: begin hit_o = 1'b1; cmd_o = C_STAT; end
              default: ;
            endcase
          end
          default: st_d = F_SEEK_HI;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= F_SEEK_HI;
    else         st_q <= st_d;
  end

  a_r4_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && byte_valid_i && byte_i == SYNC_HI |=> st_q == F_SEEK_LO);

  a_r11_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> st_q == F_SEEK_HI);

  a_r11_no_hit_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hit_o);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = en_i && !clr_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || clr_i)   cnt_q <= '0;
    else if (!expire_o)        cnt_q <= cnt_q + 1'b1;
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= limit_i);

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sup_reply.sv
module sup_reply
  import host_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       send_result_i,
  input  logic       result_pass_i,
  input  logic       send_status_i,
  input  logic [3:0] flags_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= send_result_i || send_status_i;
      if (send_result_i)      tx_data_o <= result_pass_i ? RPL_PASS : RPL_FAIL;
      else if (send_status_i) tx_data_o <= {STAT_TAG, flags_i};
    end
  end

  a_r6_single_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(send_result_i && send_status_i));
endmodule

// File: rtl/host_cmd_supervisor.sv
module host_cmd_supervisor
  import host_sup_pkg::*;
#(
  parameter int unsigned WDT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_ready_i,
  input  logic             pwr_up_done_i,
  input  logic             pwr_dn_done_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             wdt_clr_i,
  input  logic [WDT_W-1:0] wdt_limit_i,
  input  logic             run_done_i,
  input  logic             test_done_i,
  input  logic             test_pass_i,
  output logic             pwr_up_req_o,
  output logic             pwr_dn_req_o,
  output logic             run_o,
  output logic             run_valid_o,
  output logic [7:0]       run_data_o,
  output logic             test_start_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o
);
  sup_state_e state_q, state_d;
  logic amps_q, fired_q, tok_q;
  logic hit, wdt_en, wdt_exp;
  cmd_e cmd;

  assign wdt_en = amps_q && (state_q == S_MAIN || state_q == S_RUN);

  sup_frame_detect u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (state_q == S_MAIN),
    .byte_valid_i (rx_valid_i),
    .byte_i       (rx_data_i),
    .hit_o        (hit),
    .cmd_o        (cmd)
  );

  sup_watchdog #(.W(WDT_W)) u_wdt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wdt_en),
    .clr_i    (wdt_clr_i),
    .limit_i  (wdt_limit_i),
    .expire_o (wdt_exp)
  );

  sup_reply u_reply (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .send_result_i (state_q == S_TEST && test_done_i),
    .result_pass_i (test_pass_i),
    .send_status_i (state_q == S_STAT),
    .flags_i       ({1'b0, amps_q, fired_q, tok_q}),
    .tx_valid_o    (tx_valid_o),
    .tx_data_o     (tx_data_o)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_BOOT:  if (link_ready_i) state_d = S_PWRUP;
      S_PWRUP: if (pwr_up_done_i) state_d = S_MAIN;
      S_MAIN: begin
        if (wdt_exp) state_d = S_SHUT;  // expiry beats dispatch
        else if (hit) begin
          case (cmd)
            C_RUN:   state_d = S_RUN;
            C_TEST:  state_d = S_TEST;
            C_SHUT:  state_d = S_SHUT;
            default: state_d = S_STAT;
          endcase
        end
      end
      S_RUN: begin
        if (wdt_exp)                       state_d = S_SHUT;
        else if (run_done_i || wdt_clr_i)  state_d = S_MAIN;
      end
      S_TEST:  if (test_done_i) state_d = S_MAIN;
      S_STAT:  state_d = S_MAIN;
      S_SHUT:  if (pwr_dn_done_i) state_d = S_MAIN;
      default: state_d = S_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_BOOT;
      amps_q  <= 1'b0;
      fired_q <= 1'b0;
      tok_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_PWRUP && pwr_up_done_i) begin
        amps_q  <= 1'b1;
        fired_q <= 1'b0;
      end else if (wdt_exp) begin
        fired_q <= 1'b1;
      end
      if (state_q == S_SHUT && pwr_dn_done_i) amps_q <= 1'b0;
      if (state_q == S_TEST && test_done_i)   tok_q  <= test_pass_i;
    end
  end

  assign pwr_up_req_o = (state_q == S_PWRUP);
  assign pwr_dn_req_o = (state_q == S_SHUT);
  assign run_o        = (state_q == S_RUN);
  assign test_start_o = (state_q == S_TEST);
  assign run_valid_o  = run_o && rx_valid_i;
  assign run_data_o   = rx_data_i;

  a_r1_boot_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_BOOT && !link_ready_i |=> state_q == S_BOOT);

  a_r1_req_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pwr_up_req_o, pwr_dn_req_o, run_o, test_start_o}));

  a_r5_run_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_RUN && !wdt_exp && (run_done_i || wdt_clr_i) |=> state_q == S_MAIN);

  a_r6_result_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_TEST && test_done_i |=> tx_valid_o && (tx_data_o == RPL_PASS || tx_data_o == RPL_FAIL));

  a_r7_status_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_STAT |=> tx_valid_o && tx_data_o[7:4] == STAT_TAG);

  a_r8_amps_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_SHUT && pwr_dn_done_i |=> !amps_q);

  a_r9_expiry_shut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_exp |=> state_q == S_SHUT && fired_q);

  a_r10_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i |-> !wdt_exp);
endmodule

// File: tb/tb_host_cmd_supervisor.sv
module tb_host_cmd_supervisor;
  localparam int LIMIT = 40;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic link_ready_i = 0, pwr_up_done_i = 0, pwr_dn_done_i = 0;
  logic rx_valid_i = 0, wdt_clr_i = 0, run_done_i = 0, test_done_i = 0, test_pass_i = 0;
  logic [7:0] rx_data_i = '0;
  logic [15:0] wdt_limit_i = 16'(LIMIT);
  logic pwr_up_req_o, pwr_dn_req_o, run_o, run_valid_o, test_start_o, tx_valid_o;
  logic [7:0] run_data_o, tx_data_o;

  int checks = 0, errors = 0, cyc_cnt = 0;

  always #2 clk_i = ~clk_i;

  host_cmd_supervisor dut (.*);

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  // reference model: 0 boot 1 pwrup 2 main 3 run 4 test 5 stat 6 shut
  int ms = 0, fp = 0, wc = 0, nxt;
  bit amps = 0, fired = 0, tok = 0, act, ex, mtxv = 0;
  logic [7:0] mtxd = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms = 0; fp = 0; wc = 0; amps = 0; fired = 0; tok = 0; mtxv = 0;
    end else begin
      act = amps && (ms == 2 || ms == 3);
      ex  = act && !wdt_clr_i && wc == int'(wdt_limit_i);
      nxt = ms;
      mtxv = 0;
      case (ms)
        0: if (link_ready_i) nxt = 1;
        1: if (pwr_up_done_i) begin nxt = 2; amps = 1; fired = 0; end
        2: if (ex) begin nxt = 6; fired = 1; end
           else if (rx_valid_i && fp == 2 && rx_data_i inside {[1:4]})
             nxt = (rx_data_i == 1) ? 3 : (rx_data_i == 2) ? 4 : (rx_data_i == 3) ? 6 : 5;
        3: if (ex) begin nxt = 6; fired = 1; end
           else if (run_done_i || wdt_clr_i) nxt = 2;
        4: if (test_done_i) begin
             nxt = 2; mtxv = 1; mtxd = test_pass_i ? 8'h4F : 8'h45; tok = test_pass_i;
           end
        5: begin nxt = 2; mtxv = 1; mtxd = 8'hA0 + 8'(amps) * 4 + 8'(fired) * 2 + 8'(tok); end
        6: if (pwr_dn_done_i) begin nxt = 2; amps = 0; end
        default: nxt = 0;
      endcase
      if (ms != 2) fp = 0;
      else if (rx_valid_i) begin
        if (rx_data_i == 8'hFF) fp = 1;
        else if (fp == 1 && rx_data_i == 8'h00) fp = 2;
        else fp = 0;
      end
      if (!act || wdt_clr_i) wc = 0;
      else if (!ex) wc++;
      ms = nxt;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(pwr_up_req_o, ms == 1, "R1 pwr_up_req_o model");
      chk(run_o, ms == 3, "R5 run_o model");
      chk(run_valid_o, ms == 3 && rx_valid_i, "R5 run_valid_o model");
      chk(test_start_o, ms == 4, "R6 test_start_o model");
      chk(pwr_dn_req_o, ms == 6, "R8 pwr_dn_req_o model");
      chk(tx_valid_o, mtxv, "R6/R7 tx_valid_o model");
      if (mtxv) chk8(tx_data_o, mtxd, "R6/R7 tx_data_o model");
    end
  end

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc_cnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk_i); #1;
    rx_valid_i = 0; wdt_clr_i = 0; run_done_i = 0; test_done_i = 0;
    pwr_up_done_i = 0; pwr_dn_done_i = 0;
  endtask

  task automatic byte_in(input logic [7:0] b);
    cyc(); rx_valid_i = 1; rx_data_i = b;
  endtask

  task automatic kick();
    cyc(); wdt_clr_i = 1;
  endtask

  task automatic frame(input logic [7:0] op);
    kick(); byte_in(8'hFF); byte_in(8'h00); byte_in(op); cyc();
  endtask

  initial begin
    cyc(); cyc();
    chk(pwr_up_req_o, 0, "R1 reset pwr_up");
    chk(run_o, 0, "R1 reset run");
    chk(tx_valid_o, 0, "R1 reset tx");
    rst_ni = 1;
    repeat (3) cyc();
    chk(pwr_up_req_o, 0, "R1 waits for link");
    link_ready_i = 1; cyc();
    chk(pwr_up_req_o, 1, "R1 power-up request");
    pwr_up_done_i = 1; cyc();
    chk(pwr_up_req_o, 0, "R1 main reached");

    frame(8'h01);
    chk(run_o, 1, "R2 run dispatched");
    byte_in(8'h5A); #1;
    chk(run_valid_o, 1, "R5 data strobe");
    chk8(run_data_o, 8'h5A, "R5 data byte");
    byte_in(8'hC3);
    cyc(); run_done_i = 1; cyc();
    chk(run_o, 0, "R5 end on run_done");

    frame(8'h01);
    chk(run_o, 1, "R2 run again");
    cyc(); wdt_clr_i = 1; cyc();
    chk(run_o, 0, "R5 end on wdt clear");

    frame(8'h07);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(run_o | test_start_o | pwr_dn_req_o | tx_valid_o, 0, "R3 unknown code ignored");
    end

    kick(); byte_in(8'hFF); byte_in(8'hFF); byte_in(8'h00); byte_in(8'h02); cyc();
    chk(test_start_o, 1, "R4 double FF restart");
    test_pass_i = 1; test_done_i = 1; cyc();
    chk(test_start_o, 0, "R6 test done");
    chk(tx_valid_o, 1, "R6 reply strobe");
    chk8(tx_data_o, 8'h4F, "R6 pass byte");

    frame(8'h02);
    byte_in(8'hFF); byte_in(8'h00); byte_in(8'h01);
    cyc(); test_pass_i = 0; test_done_i = 1; cyc();
    chk8(tx_data_o, 8'h45, "R6 fail byte");
    cyc(); cyc();
    chk(run_o, 0, "R11 bytes during test ignored");

    kick(); byte_in(8'hFF); byte_in(8'h12); byte_in(8'h00); byte_in(8'h01); cyc();
    chk(run_o, 0, "R4 broken preamble");

    kick(); byte_in(8'hFF); byte_in(8'h00); byte_in(8'hFF); byte_in(8'h00); byte_in(8'h04);
    cyc(); cyc();
    chk(tx_valid_o, 1, "R7 status strobe");
    chk8(tx_data_o, 8'hA4, "R7 status amps on");

    kick();
    repeat (LIMIT) cyc();
    cyc(); wdt_clr_i = 1;
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk(pwr_dn_req_o, 0, "R10 clear on expiry cycle");
    end

    kick();
    repeat (LIMIT - 2) cyc();
    byte_in(8'hFF); byte_in(8'h00); byte_in(8'h01); cyc();
    chk(pwr_dn_req_o, 1, "R10 expiry beats run");
    chk(run_o, 0, "R10 no run on expiry");
    pwr_dn_done_i = 1; cyc();
    chk(pwr_dn_req_o, 0, "R8 power-down done");
    frame(8'h04); cyc();
    chk8(tx_data_o, 8'hA2, "R9 status shows fired, amps off");

    repeat (60) cyc();
    chk(pwr_dn_req_o, 0, "R9 idle while amps off");

    frame(8'h03);
    chk(pwr_dn_req_o, 1, "R8 shutdown command");
    repeat (3) cyc();
    chk(pwr_dn_req_o, 1, "R8 held until done");
    pwr_dn_done_i = 1; cyc();
    chk(pwr_dn_req_o, 0, "R8 released");
    repeat (3) cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule